// File: doc/BRIEF.md
# Latching Serial I/O Expander

This block models the far end of a serial I/O expansion chain. A host drives three lines: a shift clock, a strobe and a serial data line. The block keeps two shift stages. The output stage gathers serial bits and drives a parallel output bus through a holding register. The input stage captures a parallel input bus and sends it back one bit at a time. The output bus moves only when the strobe rises, never while bits are in flight, so a bit bound for a far pin never shows up on a nearer one.

The strobe has two jobs. Its rising edge copies the output stage into the holding register. Its inverse acts as the input stage's active-low load line, so the input stage takes the parallel inputs for as long as the strobe is high. The host needs no fourth line. Both stages have a carry pin at the end of the chain. Several units can therefore be strung together into a word of any multiple of the width.

All control lines are sampled by a system clock. Edges are found by comparing each sampled line with its value one cycle earlier. A parameter can insert synchronizer flops in front of the sampling.

Top module: `serial_io_expander`

## Requirements
- R1: While reset is asserted and right after it is released, pins_out, dout and cascade_out are all zero.
- R2: The output stage moves exactly once for each rising edge seen on shift_clk, even if the line then stays high for several cycles. On each move, din enters bit 0, every other bit moves one place toward the MSB, and cascade_out always shows bit WIDTH-1.
- R3: pins_out keeps its value in every cycle except the one in which a rising edge of strobe is seen.
- R4: On a rising edge of strobe, pins_out takes the whole output stage. After WIDTH shifts, the first bit shifted in lands on pins_out[WIDTH-1] and the last one on pins_out[0].
- R5: The input stage reloads from pins_in in every cycle in which strobe is high, so the value present in the last high cycle is the one kept. dout shows that value's bit WIDTH-1 one system clock later.
- R6: With strobe low, each rising edge of shift_clk moves the input stage one place toward the MSB. dout then shows bits WIDTH-2 down to 0 of the loaded word in turn.
- R7: At each such shift, cascade_in enters bit 0 of the input stage. After WIDTH shifts, the cascade_in bits come out on dout in the order they went in. cascade_out repeats din, WIDTH shifts later.
- R8: A rising edge of shift_clk while strobe is high does not move the input stage; the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control line |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Serial shift clock; stages move on its rising edge |
| strobe | input | 1 | Latch strobe: the rising edge updates pins_out, and the high level loads the input stage |
| din | input | 1 | Serial data into the output stage |
| cascade_in | input | 1 | Serial fill into bit 0 of the input stage, from the next unit |
| pins_in | input | WIDTH | Parallel input lines |
| dout | output | 1 | MSB of the input stage |
| cascade_out | output | 1 | MSB of the output stage, to the next unit's din |
| pins_out | output | WIDTH | Latched parallel output lines |

## Verification
A wrong bit in the output stage stays hidden on pins_out until the next strobe. It shows up earlier only if it reaches the MSB and appears on cascade_out. The bench therefore compares pins_out after each closing strobe, and cascade_out after a full word of shifts. A fault in the input stage appears on dout one system clock after the offending shift or load, so every bit read back is compared. A pins_out that moves during shifting is caught at the very next sample.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
   // Upper bound on synchronizer depth for the control lines
   localparam int SIO_MAX_SYNC = 4;

   // Bit positions of the control lines inside the bundled sync vector
   localparam int CTL_SCLK   = 0;
   localparam int CTL_STROBE = 1;
   localparam int CTL_DIN    = 2;
   localparam int CTL_CASC   = 3;
   localparam int CTL_LINES  = 4;
endpackage

// File: rtl/sio_sync.sv
`timescale 1ns/1ps
module sio_sync #(
   parameter int N      = 4,
   parameter int STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      for (genvar s = 0; s < STAGES; s++) begin : g_st
         logic [N-1:0] r;
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) r <= '0;
               else        r <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) r <= '0;
               else        r <= g_st[s-1].r;
         end
      end
      assign q = g_chain.g_st[STAGES-1].r;
   end
endmodule

// File: rtl/sio_edge.sv
`timescale 1ns/1ps
module sio_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/sio_sipo.sv
`timescale 1ns/1ps
module sio_sipo #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             ser_in,
   output logic [WIDTH-1:0] stage_q
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        stage_q <= '0;
      else if (shift_en) stage_q <= {stage_q[WIDTH-2:0], ser_in};
endmodule

// File: rtl/sio_piso.sv
`timescale 1ns/1ps
module sio_piso #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic             shift_en,
   input  logic             fill,
   input  logic [WIDTH-1:0] par,
   output logic [WIDTH-1:0] stage_q
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        stage_q <= '0;
      else if (!load_n)  stage_q <= par;
      else if (shift_en) stage_q <= {stage_q[WIDTH-2:0], fill};
endmodule

// File: rtl/sio_hold.sv
`timescale 1ns/1ps
module sio_hold #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       q <= '0;
      else if (capture) q <= d;
endmodule

// File: rtl/serial_io_expander.sv
`timescale 1ns/1ps
module serial_io_expander
   import sio_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_clk,
   input  logic             strobe,
   input  logic             din,
   input  logic             cascade_in,
   input  logic [WIDTH-1:0] pins_in,
   output logic             dout,
   output logic             cascade_out,
   output logic [WIDTH-1:0] pins_out
);
   if (WIDTH < 2) begin : g_bad_width
      $error("serial_io_expander: WIDTH must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > SIO_MAX_SYNC) begin : g_bad_sync
      $error("serial_io_expander: SYNC_STAGES out of range");
   end

   logic [CTL_LINES-1:0] ctl_raw, ctl_s;
   logic                 sclk_s, strobe_s, din_s, casc_s;
   logic [1:0]           rise;
   logic                 sclk_rise, strobe_rise, load_n;
   logic [WIDTH-1:0]     sipo_q, piso_q;

   always_comb begin
      ctl_raw             = '0;
      ctl_raw[CTL_SCLK]   = shift_clk;
      ctl_raw[CTL_STROBE] = strobe;
      ctl_raw[CTL_DIN]    = din;
      ctl_raw[CTL_CASC]   = cascade_in;
   end

   sio_sync #(.N(CTL_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
   );

   assign sclk_s   = ctl_s[CTL_SCLK];
   assign strobe_s = ctl_s[CTL_STROBE];
   assign din_s    = ctl_s[CTL_DIN];
   assign casc_s   = ctl_s[CTL_CASC];

   sio_edge #(.N(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl({strobe_s, sclk_s}), .rise(rise)
   );
   assign sclk_rise   = rise[0];
   assign strobe_rise = rise[1];

   // Input stage load line is the inverted strobe
   assign load_n = ~strobe_s;

   sio_sipo #(.WIDTH(WIDTH)) u_sipo (
      .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise), .ser_in(din_s),
      .stage_q(sipo_q)
   );

   sio_hold #(.WIDTH(WIDTH)) u_hold (
      .clk(clk), .rst_n(rst_n), .capture(strobe_rise), .d(sipo_q),
      .q(pins_out)
   );

   sio_piso #(.WIDTH(WIDTH)) u_piso (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .shift_en(sclk_rise),
      .fill(casc_s), .par(pins_in), .stage_q(piso_q)
   );

   assign cascade_out = sipo_q[WIDTH-1];
   assign dout        = piso_q[WIDTH-1];
endmodule

// File: rtl/sio_expander_chk.sv
`timescale 1ns/1ps
module sio_expander_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sclk_s,
   input logic             strobe_s,
   input logic             pin_msb,
   input logic [WIDTH-1:0] sipo_q,
   input logic             piso_next,
   input logic             dout,
   input logic             cascade_out,
   input logic [WIDTH-1:0] pins_out
);
   logic sclk_p, strobe_p, sclk_up, strobe_up;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sclk_p   <= 1'b0;
         strobe_p <= 1'b0;
      end else begin
         sclk_p   <= sclk_s;
         strobe_p <= strobe_s;
      end

   assign sclk_up   = sclk_s & ~sclk_p;
   assign strobe_up = strobe_s & ~strobe_p;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (pins_out == '0 && dout == 1'b0 && cascade_out == 1'b0));

   // R2
   sipo_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_up |=> cascade_out == $past(sipo_q[WIDTH-2]));

   // R2
   sipo_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_up |=> $stable(cascade_out));

   // R3
   pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_up |=> $stable(pins_out));

   // R4
   pins_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_up |=> pins_out == $past(sipo_q));

   // R5
   piso_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_s |=> dout == $past(pin_msb));

   // R6
   piso_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_s && sclk_up) |=> dout == $past(piso_next));

   // R6
   piso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_s && !sclk_up) |=> $stable(dout));

   // R8
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_s && sclk_up) |=> dout == $past(pin_msb));
endmodule

bind serial_io_expander sio_expander_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .strobe_s(strobe_s),
   .pin_msb(pins_in[WIDTH-1]), .sipo_q(sipo_q), .piso_next(piso_q[WIDTH-2]),
   .dout(dout), .cascade_out(cascade_out), .pins_out(pins_out)
);

// File: tb/sim_serial_io_expander.sv
`timescale 1ns/1ps
module sim_serial_io_expander;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         shift_clk = 1'b0, strobe = 1'b0, din = 1'b0, cascade_in = 1'b0;
   logic [W-1:0] pins_in = '0;
   logic         dout, cascade_out;
   logic [W-1:0] pins_out;

   int checks = 0;
   int fails  = 0;
   logic [W-1:0] model_sipo = '0;
   logic [W-1:0] exp_pins   = '0;

   always #2.5 clk = ~clk;

   serial_io_expander #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .strobe(strobe),
      .din(din), .cascade_in(cascade_in), .pins_in(pins_in),
      .dout(dout), .cascade_out(cascade_out), .pins_out(pins_out)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Starts and ends on a falling clk edge; returns dout as seen before the shift
   task automatic shift_bit(input logic b, input logic cin, output logic got);
      got        = dout;
      din        = b;
      cascade_in = cin;
      shift_clk  = 1'b1;
      @(negedge clk);
      shift_clk  = 1'b0;
      model_sipo = {model_sipo[W-2:0], b};
      @(negedge clk);
   endtask

   task automatic pulse_strobe();
      strobe   = 1'b1;
      exp_pins = model_sipo;
      @(negedge clk);
      strobe   = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 pins_out", pins_out, '0);
      check("R1 dout", W'(dout), '0);
      check("R1 cascade_out", W'(cascade_out), '0);
   endtask

   task automatic t_frame(input logic [W-1:0] ow, input logic [W-1:0] iw);
      logic got;
      pins_in = iw;
      pulse_strobe();
      check("R4 pins_out after opening strobe", pins_out, exp_pins);
      for (int i = W - 1; i >= 0; i--) begin
         shift_bit(ow[i], 1'b0, got);
         if (i == W - 1) check("R5 dout msb", W'(got), W'(iw[i]));
         else            check("R6 dout bit", W'(got), W'(iw[i]));
         check("R3 pins_out steady while shifting", pins_out, exp_pins);
      end
      check("R2 cascade_out after full word", W'(cascade_out), W'(ow[W-1]));
      pulse_strobe();
      check("R4 pins_out after closing strobe", pins_out, ow);
   endtask

   task automatic t_cascade(input logic [W-1:0] a, input logic [W-1:0] c,
                            input logic [W-1:0] x, input logic [W-1:0] y);
      logic got;
      pins_in = a;
      pulse_strobe();
      for (int k = 0; k < 2 * W; k++) begin
         logic co;
         co = cascade_out;
         if (k < W) shift_bit(x[W-1-k], c[W-1-k], got);
         else       shift_bit(y[2*W-1-k], 1'b0, got);
         if (k < W) check("R6 chained first word", W'(got), W'(a[W-1-k]));
         else begin
            check("R7 cascade_in bits on dout", W'(got), W'(c[2*W-1-k]));
            check("R7 cascade_out repeats din", W'(co), W'(x[2*W-1-k]));
         end
      end
      pulse_strobe();
      check("R4 pins_out holds last word of chain", pins_out, y);
   endtask

   task automatic t_edge();
      logic got;
      din       = 1'b1;
      shift_clk = 1'b1;
      repeat (4) @(negedge clk);
      shift_clk  = 1'b0;
      din        = 1'b0;
      model_sipo = {model_sipo[W-2:0], 1'b1};
      @(negedge clk);
      for (int i = 0; i < W - 1; i++) shift_bit(1'b0, 1'b0, got);
      check("R2 held shift_clk shifts once (cascade_out)", W'(cascade_out), W'(1));
      pulse_strobe();
      check("R2 held shift_clk shifts once (pins_out)", pins_out, W'(1) << (W - 1));
   endtask

   task automatic t_load_wins(input logic [W-1:0] p1, input logic [W-1:0] p2);
      logic got;
      pins_in  = p1;
      strobe   = 1'b1;
      exp_pins = model_sipo;
      @(negedge clk);
      check("R5 dout tracks load while strobe high", W'(dout), W'(p1[W-1]));
      pins_in    = p2;
      din        = 1'b0;
      cascade_in = 1'b1;
      shift_clk  = 1'b1;
      @(negedge clk);
      shift_clk  = 1'b0;
      model_sipo = {model_sipo[W-2:0], 1'b0};
      @(negedge clk);
      strobe     = 1'b0;
      cascade_in = 1'b0;
      @(negedge clk);
      check("R8 input stage unmoved by shift under strobe", W'(dout), W'(p2[W-1]));
      check("R3 pins_out captured once", pins_out, exp_pins);
      for (int i = W - 1; i >= 0; i--) begin
         shift_bit(1'b0, 1'b0, got);
         check("R5 last loaded word read back", W'(got), W'(p2[i]));
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frame(16'hC3A5, 16'h9F01);
      t_frame(16'h0001, 16'h8000);
      t_frame(16'hFFFF, 16'h5AA5);
      t_cascade(16'h1234, 16'hBEEF, 16'hF00D, 16'h6E73);
      t_edge();
      t_load_wins(16'hA5C3, 16'h3C5A);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule